// File: doc/BRIEF.md
# I2C Stop Condition Generator

This block is the Stop-condition sequencer of an I2C master on an open-drain bus. A one-cycle request makes it pull SDA low while SCL is still held low. It then lets SCL float and waits until SCL really reads high, so a device that stretches the clock simply lengthens the wait. Once SCL is high, a reloadable down-counter times the hold phase. After that SDA is released, and a second timed phase confirms that SDA has risen.

Collisions are detected at two points. In the first, SCL is pulled low by someone else after SCL was released and before SDA was confirmed high. In the second, SDA still reads low at the end of the final phase. On either collision the block drops both drives at once, returns to idle and raises a sticky collision flag. On success it sets a stop-seen flag and pulses an interrupt for one clock. Bus inputs are resynchronised by a flop chain before use.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, both drive outputs, `stop_pending`, `stop_seen`, `irq` and `bus_col` are 0.
- R2: On the clock after an accepted request, both `sda_drive_low` and `scl_drive_low` are 1. SCL is released only while SDA is still driven low.
- R3: With no clock stretching and reload value N (1..127), exactly N+3 clock cycles pass with SDA driven low and SCL released before SDA is released. These cycles are 2 synchroniser cycles, 1 detection cycle and N counter ticks.
- R4: If another device holds SCL low until K cycles after the block releases it, the cycle count from R3 becomes K+N+2. SDA stays driven low throughout the stretch.
- R5: A reload value of 0 behaves exactly like a reload value of 1.
- R6: After SDA is released, the block stays pending for N+2 cycles. If SDA reads high at the end, it sets `stop_seen`, pulses `irq` high for exactly one cycle and clears `stop_pending`.
- R7: If SDA still reads low at the end of the final phase, `bus_col` is set, both drives are released, `stop_pending` clears, and neither `stop_seen` nor `irq` is set.
- R8: If SCL is pulled low during either timed phase, `bus_col` is set within 3 cycles, both drives are released and `stop_pending` clears.
- R9: `bus_col` remains set until `bcol_clr` is pulsed. While it is set, `stop_req` is ignored and `stop_pending` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle request to generate a Stop |
| reload | input | 7 | Counter reload for each timed phase (0 acts as 1) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| bcol_clr | input | 1 | Write-one-to-clear for `bus_col` |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 lets it float |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 lets it float |
| stop_pending | output | 1 | Sequence in progress |
| stop_seen | output | 1 | Last sequence completed; cleared on next accepted request |
| irq | output | 1 | One-cycle completion pulse |
| bus_col | output | 1 | Sticky bus-collision flag |

## Verification
The checker watches, on every cycle, the ordering of the two drives and the one-cycle width of the interrupt. It also checks that a collision always releases both lines and never shows up alongside a success, and that the collision flag holds and blocks new requests until it is cleared. The exact phase lengths for different reload values and stretch lengths, the treatment of a zero reload, and the two collision scenarios depend on the bus behaviour that the bench models. Those are shown only by the bench's scenarios, which count cycles at the ports.

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen #(
  parameter int RW   = 7,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic [RW-1:0] reload,
  input  logic          sda_in,
  input  logic          scl_in,
  input  logic          bcol_clr,
  output logic          sda_drive_low,
  output logic          scl_drive_low,
  output logic          stop_pending,
  output logic          stop_seen,
  output logic          irq,
  output logic          bus_col
);
  localparam int CW = RW + 1;

  typedef enum logic [2:0] {S_IDLE, S_PULL, S_SCLREL, S_HOLD, S_RISE} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [SYNC-1:0] sda_sh, scl_sh;

  wire sda_s = sda_sh[SYNC-1];
  wire scl_s = scl_sh[SYNC-1];

  wire [CW-1:0] eff = (reload == '0) ? CW'(1) : CW'(reload);
  wire accept   = stop_req && (st == S_IDLE) && !bus_col;
  wire tick_end = (cnt == CW'(1));
  wire col_scl  = ((st == S_HOLD) || (st == S_RISE)) && !scl_s;
  wire col_sda  = (st == S_RISE) && tick_end && !sda_s;
  wire col      = col_scl || col_sda;
  wire done     = (st == S_RISE) && tick_end && sda_s && !col_scl;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sda_sh <= '1;
          scl_sh <= '1;
        end else begin
          sda_sh <= sda_in;
          scl_sh <= scl_in;
        end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sda_sh <= '1;
          scl_sh <= '1;
        end else begin
          sda_sh <= {sda_sh[SYNC-2:0], sda_in};
          scl_sh <= {scl_sh[SYNC-2:0], scl_in};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE:   if (accept) st <= S_PULL;
        S_PULL:   if (!sda_s && !scl_s) st <= S_SCLREL;
        S_SCLREL: if (scl_s) begin
                    st  <= S_HOLD;
                    cnt <= eff;
                  end
        S_HOLD:   if (col) st <= S_IDLE;
                  else if (tick_end) begin
                    st  <= S_RISE;
                    cnt <= eff + CW'(SYNC);
                  end else cnt <= cnt - CW'(1);
        S_RISE:   if (col || done) st <= S_IDLE;
                  else cnt <= cnt - CW'(1);
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_col   <= 1'b0;
      stop_seen <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (col)           bus_col <= 1'b1;
      else if (bcol_clr) bus_col <= 1'b0;
      if (accept)        stop_seen <= 1'b0;
      else if (done)     stop_seen <= 1'b1;
      irq <= done;
    end
  end

  assign sda_drive_low = (st == S_PULL) || (st == S_SCLREL) || (st == S_HOLD);
  assign scl_drive_low = (st == S_PULL);
  assign stop_pending  = (st != S_IDLE);
endmodule

// File: rtl/i2c_stop_gen_chk.sv
module i2c_stop_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic bcol_clr,
  input logic sda_drive_low,
  input logic scl_drive_low,
  input logic stop_pending,
  input logic stop_seen,
  input logic irq,
  input logic bus_col
);
  p_scl_after_sda_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> sda_drive_low);

  p_scl_only_with_sda_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> sda_drive_low);

  p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_with_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stop_seen && !stop_pending && !$rose(bus_col)));

  p_col_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_col) |-> (!sda_drive_low && !scl_drive_low && !stop_pending && !irq));

  p_col_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_col && !bcol_clr) |=> bus_col);

  p_req_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_col && !stop_pending) |=> !stop_pending);
endmodule

bind i2c_stop_gen i2c_stop_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .bcol_clr(bcol_clr),
  .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
  .stop_pending(stop_pending), .stop_seen(stop_seen), .irq(irq), .bus_col(bus_col)
);

// File: tb/i2c_stop_gen_tb.sv
module i2c_stop_gen_tb;
  logic clk = 0, rst_n = 0, stop_req = 0, bcol_clr = 0;
  logic [6:0] reload = 7'd5;
  logic ext_sda = 0, ext_scl = 0;
  logic sda_drive_low, scl_drive_low, stop_pending, stop_seen, irq, bus_col;
  wire sda_in = !(sda_drive_low || ext_sda);
  wire scl_in = !(scl_drive_low || ext_scl);
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  i2c_stop_gen u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .sda_in(sda_in), .scl_in(scl_in), .bcol_clr(bcol_clr),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .stop_pending(stop_pending), .stop_seen(stop_seen), .irq(irq), .bus_col(bus_col)
  );

  localparam int NV = 6;
  localparam logic [6:0] V_RL [NV] = '{7'd5, 7'd0, 7'd1, 7'd3, 7'd12, 7'd127};
  localparam int         V_K  [NV] = '{0, 0, 0, 4, 2, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_stop(input int k, output int f_sda, output int f_scl,
                          output int w1, output int w2);
    int reln = 0;
    w1 = 0; w2 = 0;
    ext_scl = (k > 0);
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    f_sda = sda_drive_low; f_scl = scl_drive_low;
    for (int i = 0; i < 2000; i++) begin
      if (sda_drive_low && !scl_drive_low) begin
        w1++; reln++;
        if (reln == k) ext_scl = 0;
      end
      if (stop_pending && !sda_drive_low) w2++;
      if (!stop_pending) break;
      @(negedge clk);
    end
    ext_scl = 0;
  endtask

  initial begin
    #1ms;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f_sda, f_scl, w1, w2, n, irq_now, irq_next;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sda_drive_low && !scl_drive_low && !stop_pending && !stop_seen && !irq && !bus_col,
        "R1 reset outputs", {sda_drive_low, scl_drive_low, stop_pending, stop_seen, irq, bus_col}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      reload = V_RL[v];
      n = (V_RL[v] == 0) ? 1 : int'(V_RL[v]);
      run_stop(V_K[v], f_sda, f_scl, w1, w2);
      irq_now = irq;
      @(negedge clk);
      irq_next = irq;
      chk(f_sda == 1 && f_scl == 1, "R2 both low after request", f_sda * 2 + f_scl, 3);
      if (V_K[v] == 0) begin
        if (V_RL[v] == 0) chk(w1 == n + 3, "R5 zero reload acts as one", w1, n + 3);
        else              chk(w1 == n + 3, "R3 hold window", w1, n + 3);
      end else
        chk(w1 == V_K[v] + n + 2, "R4 stretched hold window", w1, V_K[v] + n + 2);
      chk(w2 == n + 2, "R6 rise window", w2, n + 2);
      chk(irq_now == 1 && irq_next == 0, "R6 irq single pulse", irq_now * 2 + irq_next, 2);
      chk(stop_seen == 1 && bus_col == 0, "R6 stop_seen set", stop_seen, 1);
      repeat (2) @(negedge clk);
    end

    // R7: SDA held low by another master
    reload = 7'd4;
    ext_sda = 1;
    run_stop(0, f_sda, f_scl, w1, w2);
    irq_now = irq;
    chk(bus_col == 1, "R7 sda collision flag", bus_col, 1);
    chk(stop_seen == 0 && irq_now == 0, "R7 no success", stop_seen + irq_now, 0);
    chk(!sda_drive_low && !scl_drive_low && !stop_pending, "R7 drives released",
        sda_drive_low + scl_drive_low + stop_pending, 0);
    ext_sda = 0;

    // R9: sticky and request blocked
    repeat (5) @(negedge clk);
    chk(bus_col == 1, "R9 flag sticky", bus_col, 1);
    stop_req = 1; @(negedge clk); stop_req = 0;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      n += stop_pending; @(negedge clk);
    end
    chk(n == 0 && !sda_drive_low, "R9 request ignored", n, 0);
    bcol_clr = 1; @(negedge clk); bcol_clr = 0;
    chk(bus_col == 0, "R9 cleared by bcol_clr", bus_col, 0);

    // R8: SCL pulled low during hold phase
    reload = 7'd20;
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    w1 = 0;
    for (int i = 0; i < 100 && w1 < 8; i++) begin
      if (sda_drive_low && !scl_drive_low) w1++;
      @(negedge clk);
    end
    ext_scl = 1;
    n = 0;
    for (int i = 0; i < 10 && !bus_col; i++) begin
      n++; @(negedge clk);
    end
    chk(bus_col == 1 && n <= 3, "R8 scl collision latency", n, 3);
    chk(!sda_drive_low && !scl_drive_low && !stop_pending && !stop_seen, "R8 drives released",
        sda_drive_low + scl_drive_low + stop_pending + stop_seen, 0);
    ext_scl = 0;
    bcol_clr = 1; @(negedge clk); bcol_clr = 0;
    @(negedge clk);

    // R8: SCL pulled low during rise phase
    reload = 7'd10;
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    for (int i = 0; i < 200 && sda_drive_low; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    ext_scl = 1;
    n = 0;
    for (int i = 0; i < 10 && !bus_col; i++) begin
      n++; @(negedge clk);
    end
    chk(bus_col == 1 && !stop_seen && !stop_pending, "R8 rise-phase collision", n, 3);
    ext_scl = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule